// File: doc/BRIEF.md
# Serial Flash 1-Bit Audio Streamer

This block drives a serial flash with the usual four SPI lines plus the hold pin, and adds a free-running stream mode. Software first pulls chip select low with a control write, then bit-bangs a read command and address through the data port, one bit per write. A control write that selects stream mode then starts a serial clock derived from the CPU clock by a fixed divider. Every bit the flash returns is latched on the rising serial clock edge and sent straight to a single-bit audio output, which an external filter turns into sound.

Three control bits set the operating state. One bit deselects the flash. A second bit chooses between stream mode and byte mode; in byte mode the clock is never free-running. A third bit drives the hold pin, which pauses the stream without losing its place. While the stream is paused or the flash is deselected, the serial clock rests low and the audio output keeps its last sample.

Top module: `spi_audio_streamer`

## Requirements
- R1: After reset spi_cs_n=1, spi_hold_n=1, spi_sck=0, spi_mosi=0 and audio_out=0.
- R2: A write with wr_ctrl=1 sets spi_cs_n to wr_data[7] on the next cycle, and sets spi_hold_n to the inverse of wr_data[5] (bit 5 = 1 asserts hold).
- R3: The free-running serial clock runs only after a control write with wr_data[7]=0 and wr_data[6]=0 (stream mode). A control write with wr_data[6]=1 (byte mode) stops it, and it never starts in byte mode.
- R4: In stream mode spi_sck has DIV_HALF clock cycles low and DIV_HALF high. The first rising edge comes DIV_HALF cycles after the starting control write.
- R5: While hold is asserted or the flash is deselected, spi_sck stays low and audio_out does not change.
- R6: audio_out takes the value of spi_miso at each rising spi_sck edge in stream mode. After a hold is released, the samples continue with the next flash bit.
- R7: When not streaming, a write with wr_ctrl=0 puts wr_data[7] on spi_mosi on the next cycle. spi_sck is then high for exactly one cycle, the second cycle after the write.
- R8: Data writes (wr_ctrl=0) while streaming are ignored: spi_mosi keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ctrl | input | 1 | 1 selects the control register, 0 the serial data port |
| wr_data | input | 8 | Write data |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_hold_n | output | 1 | Flash hold, active low |
| audio_out | output | 1 | 1-bit PCM audio sample |

## Verification
The assertions check the following on every cycle:
- the serial clock rests low when the divider is not enabled;
- the audio output changes only on a rising serial clock;
- each clock high phase lasts more than one cycle;
- a bit-bang pulse is a single cycle;
- MOSI stays stable during streaming;
- the control bits reach the pins.

Only the bench scenarios can show the rest:
- the exact half-period length and the delay before the first rising edge;
- that the samples follow the flash's bit order, including across a hold and resume;
- that byte mode never starts the free-running clock.

// File: rtl/spi_aud_pkg.sv
package spi_aud_pkg;
  localparam int CTRL_DESEL_BIT = 7;
  localparam int CTRL_BYTE_BIT  = 6;
  localparam int CTRL_HOLD_BIT  = 5;
  localparam int DATA_BIT       = 7;

  typedef struct packed {
    logic desel;
    logic byte_mode;
    logic hold;
  } ctrl_t;
endpackage

// File: rtl/sas_ctrl_reg.sv
module sas_ctrl_reg
  import spi_aud_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_ctrl,
  input  logic [7:0] wr_data,
  output logic       cs_n_o,
  output logic       hold_n_o,
  output logic       run_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  run_q, run_d;
  logic  ctrl_we;

  assign ctrl_we = wr_en & wr_ctrl;

  always_comb begin
    ctrl_d = ctrl_q;
    run_d  = run_q;
    if (ctrl_we) begin
      ctrl_d.desel     = wr_data[CTRL_DESEL_BIT];
      ctrl_d.byte_mode = wr_data[CTRL_BYTE_BIT];
      ctrl_d.hold      = wr_data[CTRL_HOLD_BIT];
      run_d = ~wr_data[CTRL_DESEL_BIT] & ~wr_data[CTRL_BYTE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{desel: 1'b1, byte_mode: 1'b1, hold: 1'b0};
      run_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      run_q  <= run_d;
    end
  end

  assign cs_n_o   = ctrl_q.desel;
  assign hold_n_o = ~ctrl_q.hold;
  assign run_o    = run_q;

  AST_CS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (cs_n_o == $past(wr_data[CTRL_DESEL_BIT])) && (hold_n_o == !$past(wr_data[CTRL_HOLD_BIT]))); // R2
endmodule

// File: rtl/sas_stream_clk.sv
module sas_stream_clk #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic miso_i,
  output logic sck_o,
  output logic audio_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LIM = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          aud_q, aud_d;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    aud_d = aud_q;
    if (!en_i) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (cnt_q == LIM) begin
      cnt_d = '0;
      sck_d = ~sck_q;
      if (!sck_q) aud_d = miso_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      aud_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
      aud_q <= aud_d;
    end
  end

  assign sck_o   = sck_q;
  assign audio_o = aud_q;

  AST_SCK_PARKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !sck_o); // R5
  AST_AUDIO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_o != $past(audio_o)) |-> $rose(sck_o)); // R6

  generate
    if (DIV_HALF > 1) begin : g_wide
      AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sck_o) && en_i) |=> (sck_o || !en_i)); // R4
    end
  endgenerate
endmodule

// File: rtl/sas_bitbang.sv
module sas_bitbang (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic bit_i,
  output logic mosi_o,
  output logic sck_o
);
  typedef enum logic [1:0] {BB_IDLE, BB_RISE, BB_FALL} bb_st_t;

  bb_st_t st_q, st_d;
  logic   mosi_q, mosi_d;
  logic   sck_q, sck_d;

  always_comb begin
    st_d   = st_q;
    mosi_d = mosi_q;
    sck_d  = 1'b0;
    case (st_q)
      BB_RISE: begin sck_d = 1'b1; st_d = BB_FALL; end
      BB_FALL: st_d = BB_IDLE;
      default: st_d = BB_IDLE;
    endcase
    if (wr_i) begin
      mosi_d = bit_i;
      st_d   = BB_RISE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BB_IDLE;
      mosi_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mosi_q <= mosi_d;
      sck_q  <= sck_d;
    end
  end

  assign mosi_o = mosi_q;
  assign sck_o  = sck_q;

  AST_BB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |=> !sck_o); // R7
endmodule

// File: rtl/spi_audio_streamer.sv
module spi_audio_streamer
  import spi_aud_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_ctrl,
  input  logic [7:0] wr_data,
  input  logic       spi_miso,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  output logic       spi_hold_n,
  output logic       audio_out
);
  logic run;
  logic div_en;
  logic div_sck;
  logic bb_sck;
  logic bb_wr;

  sas_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ctrl  (wr_ctrl),
    .wr_data  (wr_data),
    .cs_n_o   (spi_cs_n),
    .hold_n_o (spi_hold_n),
    .run_o    (run)
  );

  assign div_en = run & spi_hold_n;

  sas_stream_clk #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (div_en),
    .miso_i  (spi_miso),
    .sck_o   (div_sck),
    .audio_o (audio_out)
  );

  assign bb_wr = wr_en & ~wr_ctrl & ~run;

  sas_bitbang u_bb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (bb_wr),
    .bit_i  (wr_data[DATA_BIT]),
    .mosi_o (spi_mosi),
    .sck_o  (bb_sck)
  );

  assign spi_sck = run ? div_sck : bb_sck;

  AST_MOSI_FROZEN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(spi_mosi)); // R8
endmodule

// File: tb/spi_audio_streamer_bench.sv
module spi_audio_streamer_bench;
  localparam int DIV_HALF = 4;
  localparam logic [15:0] PAT = 16'hB4D2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_ctrl = 1'b0;
  logic [7:0] wr_data = '0;
  logic       spi_miso;
  logic       spi_cs_n, spi_sck, spi_mosi, spi_hold_n, audio_out;

  int checks = 0;
  int failures = 0;
  int idx = 0;
  int nsamp = 0;
  bit flash_on = 1'b0;

  always #5 clk = ~clk;

  spi_audio_streamer #(.DIV_HALF(DIV_HALF)) u_spi_audio_streamer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_hold_n(spi_hold_n), .audio_out(audio_out)
  );

  // flash model: a new bit appears after each falling clock while selected and not held
  assign spi_miso = PAT[idx % 16];
  always @(negedge spi_sck)
    if (flash_on && spi_hold_n && !spi_cs_n) idx <= idx + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit ctrl, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ctrl = ctrl; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_hold_n == 1'b1, "R1 hold_n", spi_hold_n, 1);
    chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
    chk(spi_mosi == 1'b0, "R1 mosi", spi_mosi, 0);
    chk(audio_out == 1'b0, "R1 audio", audio_out, 0);
  endtask

  task automatic t_byte_mode();
    wr(1'b1, 8'h40);
    chk(spi_cs_n == 1'b0, "R2 cs_n low", spi_cs_n, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(spi_sck == 1'b0, "R3 no clock in byte mode", spi_sck, 0);
    end
  endtask

  task automatic t_bitbang();
    wr(1'b0, 8'h80);
    chk(spi_mosi == 1'b1, "R7 mosi set", spi_mosi, 1);
    chk(spi_sck == 1'b0, "R7 sck low first", spi_sck, 0);
    @(negedge clk);
    chk(spi_sck == 1'b1, "R7 sck pulse", spi_sck, 1);
    @(negedge clk);
    chk(spi_sck == 1'b0, "R7 sck back low", spi_sck, 0);
    wr(1'b0, 8'h7F);
    chk(spi_mosi == 1'b0, "R7 mosi clear", spi_mosi, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic take_samples(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge spi_sck);
      #1;
      chk(audio_out == PAT[nsamp % 16], "R6 audio sample", audio_out, PAT[nsamp % 16]);
      nsamp++;
    end
  endtask

  task automatic t_stream();
    int lo, hi;
    idx = 0; nsamp = 0; flash_on = 1'b1;
    wr(1'b1, 8'h00);
    lo = 0;
    while (spi_sck == 1'b0 && lo < 50) begin
      @(negedge clk);
      lo++;
    end
    chk(lo == DIV_HALF, "R4 first rise delay", lo, DIV_HALF);
    chk(audio_out == PAT[0], "R6 first sample", audio_out, PAT[0]);
    nsamp = 1;
    hi = 0;
    while (spi_sck == 1'b1 && hi < 50) begin
      @(negedge clk);
      hi++;
    end
    chk(hi == DIV_HALF, "R4 high phase", hi, DIV_HALF);
    lo = 0;
    while (spi_sck == 1'b0 && lo < 50) begin
      @(negedge clk);
      lo++;
    end
    chk(lo == DIV_HALF, "R4 low phase", lo, DIV_HALF);
    nsamp = 2;
    take_samples(10);
  endtask

  task automatic t_hold();
    logic a;
    @(negedge spi_sck);
    wr(1'b1, 8'h20);
    chk(spi_hold_n == 1'b0, "R2 hold_n asserted", spi_hold_n, 0);
    a = audio_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(spi_sck == 1'b0 && audio_out == a, "R5 paused by hold", {spi_sck, audio_out}, {1'b0, a});
    end
    wr(1'b1, 8'h00);
    chk(spi_hold_n == 1'b1, "R2 hold_n released", spi_hold_n, 1);
    take_samples(6);
  endtask

  task automatic t_mosi_ignored();
    logic m;
    m = spi_mosi;
    wr(1'b0, {~m, 7'h00});
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(spi_mosi == m, "R8 data write ignored", spi_mosi, m);
    end
  endtask

  task automatic t_deselect();
    logic a;
    @(negedge spi_sck);
    wr(1'b1, 8'h80);
    chk(spi_cs_n == 1'b1, "R2 cs_n high", spi_cs_n, 1);
    a = audio_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(spi_sck == 1'b0 && audio_out == a, "R5 stopped by deselect", {spi_sck, audio_out}, {1'b0, a});
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_byte_mode();
    t_bitbang();
    t_stream();
    t_hold();
    t_mosi_ignored();
    t_deselect();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule